// File: doc/BRIEF.md
# Branch Target Buffer with Prediction Statistics

This block is a small fully associative table that maps branch instruction addresses to the targets they last resolved to. In the fetch stage the current fetch address is compared against every row at once. When a live row matches and that row's track record is not negative, the block offers the stored target as the next fetch address. Each time such a prediction is taken, the row's prediction counter advances.

When a branch resolves later in the pipeline, the resolution port reports the branch address, its actual target, and whether the earlier prediction was right. A row that already holds the branch takes the new target, and its signed success score moves one step up or down. A branch that has no row gets one: the lowest empty row if any row is empty, otherwise a victim chosen in rotating order. Rows whose score has dropped below zero still match but do not predict, so fetch falls through sequentially for them.

Top module: `btb_stats`

## Requirements
- R1: A synchronous active-high reset invalidates every row and sets the rotating victim pointer to row 0. In the first cycle after reset no lookup address matches (`rowMatch`=0, `predHit`=0).
- R2: Lookup is combinational. When `lookupAddr` equals the address of a valid row whose score is 0 or more, `predHit`=1 and `predTarget` is that row's target in the same cycle. When no valid row matches, `rowMatch`, `predHit`, `predTarget`, `rowCount` and `rowScore` are all 0.
- R3: When the matching row's score is negative, `rowMatch`=1 and `predHit`=0. A lookup with `lookupValid`=1 then leaves that row's count unchanged.
- R4: A cycle with `lookupValid`=1 and `predHit`=1 raises the matching row's 8-bit count by one at the next edge. The count stays at 255 once it gets there.
- R5: A resolution (`resValid`=1) whose `resAddr` matches a valid row writes `resTarget` into that row at the next edge.
- R6: A matching resolution adds 1 to the row's 4-bit two's-complement score when `resCorrect`=1 and subtracts 1 when `resCorrect`=0. The score stops at +7 and at -8.
- R7: A resolution whose address matches no valid row allocates the lowest-numbered invalid row. The new row gets `resTarget`, count 0 and score 0, and `resCorrect` has no effect on it.
- R8: If all 8 rows are valid, an allocating resolution replaces the row named by the rotating pointer. The pointer then advances by one and wraps from 7 back to 0. Since rows fill in order 0 to 7, the first branch ever allocated is the first to be evicted.
- R9: If a resolution writes the same row that a same-cycle lookup hit would count, the resolution is applied and the count increment is dropped.
- R10: A lookup hit on one row and a resolution on a different row in the same cycle both take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookupValid | input | 1 | Fetch lookup is live; a hit counts as a prediction made |
| lookupAddr | input | 32 | Fetch address compared against all rows |
| rowMatch | output | 1 | A valid row holds `lookupAddr` |
| predHit | output | 1 | Matching row has score of 0 or more; use `predTarget` |
| predTarget | output | 32 | Stored target of the matching row |
| rowCount | output | 8 | Prediction count of the matching row |
| rowScore | output | 4 | Signed success score of the matching row |
| resValid | input | 1 | Branch resolution strobe |
| resAddr | input | 32 | Address of the resolved branch |
| resTarget | input | 32 | Actual target of the resolved branch |
| resCorrect | input | 1 | The earlier prediction for this branch was right |

## Verification
A fetch-side hit can land in the same cycle as a branch resolution. The two may target the same row, where the resolution must win and the count must stay put, or different rows, where both updates must land. The bench provokes both on purpose: it drives `lookupValid` with an address while resolving that same address or another one in the same cycle. A long random phase over a small address pool then makes these collisions, including the eviction of a row that is being hit, happen often. A behavioural reference model applies the rules in the requirements, and every cycle the lookup outputs for the current address are compared with the model's match, hit, target, count and score.

// File: rtl/btb_stats_pkg.sv
package btb_stats_pkg;
  localparam int ROWS  = 8;
  localparam int IDX_W = $clog2(ROWS);

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             wrEn;    // write a row from the resolution port
    logic             wrAlloc; // write is a fresh allocation
    logic [IDX_W-1:0] wrIdx;
    logic             cntEn;   // bump prediction count
    logic [IDX_W-1:0] cntIdx;
  } btbStrobe_t;
endpackage

// File: rtl/btb_stats_dp.sv
module btb_stats_dp
  import btb_stats_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int SCORE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         lookupAddr,
  input  logic [ADDR_W-1:0]         resAddr,
  input  logic [ADDR_W-1:0]         resTarget,
  input  logic                      resCorrect,
  input  btbStrobe_t                strobe,
  output logic [ROWS-1:0]           validVec,
  output logic [ROWS-1:0]           lookHitVec,
  output logic [ROWS-1:0]           resMatchVec,
  output logic                      rowMatch,
  output logic                      predHit,
  output logic [ADDR_W-1:0]         predTarget,
  output logic [CNT_W-1:0]          rowCount,
  output logic signed [SCORE_W-1:0] rowScore
);
  localparam logic [CNT_W-1:0]          CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]          CNT_ONE   = CNT_W'(1);
  localparam logic signed [SCORE_W-1:0] SCORE_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
  localparam logic signed [SCORE_W-1:0] SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};
  localparam logic signed [SCORE_W-1:0] SCORE_ONE = SCORE_W'(1);

  logic                      validQ [ROWS];
  logic [ADDR_W-1:0]         tagQ   [ROWS];
  logic [ADDR_W-1:0]         tgtQ   [ROWS];
  logic [CNT_W-1:0]          cntQ   [ROWS];
  logic signed [SCORE_W-1:0] scoreQ [ROWS];
  logic [ROWS-1:0]           lookMatchVec;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [SCORE_W-1:0] scoreNext;
    logic                      wrHere;
    logic                      cntHere;

    assign lookMatchVec[r] = validQ[r] && (tagQ[r] == lookupAddr);
    assign lookHitVec[r]   = lookMatchVec[r] && !scoreQ[r][SCORE_W-1];
    assign resMatchVec[r]  = validQ[r] && (tagQ[r] == resAddr);
    assign validVec[r]     = validQ[r];
    assign wrHere  = strobe.wrEn  && (strobe.wrIdx  == IDX_W'(r));
    assign cntHere = strobe.cntEn && (strobe.cntIdx == IDX_W'(r));

    always_comb begin
      if (resCorrect)
        scoreNext = (scoreQ[r] == SCORE_MAX) ? scoreQ[r] : scoreQ[r] + SCORE_ONE;
      else
        scoreNext = (scoreQ[r] == SCORE_MIN) ? scoreQ[r] : scoreQ[r] - SCORE_ONE;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[r] <= 1'b0;
      end else if (wrHere) begin
        validQ[r] <= 1'b1;
        tagQ[r]   <= resAddr;
        tgtQ[r]   <= resTarget;
        if (strobe.wrAlloc) begin
          cntQ[r]   <= '0;
          scoreQ[r] <= '0;
        end else begin
          scoreQ[r] <= scoreNext;
        end
      end else if (cntHere && (cntQ[r] != CNT_MAX)) begin
        cntQ[r] <= cntQ[r] + CNT_ONE;
      end
    end
  end

  // read mux: at most one row can match a given address
  always_comb begin
    rowMatch   = 1'b0;
    predTarget = '0;
    rowCount   = '0;
    rowScore   = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (lookMatchVec[i]) begin
        rowMatch   = 1'b1;
        predTarget = tgtQ[i];
        rowCount   = cntQ[i];
        rowScore   = scoreQ[i];
      end
    end
    predHit = rowMatch && !rowScore[SCORE_W-1];
  end
endmodule

// File: rtl/btb_stats_ctrl.sv
module btb_stats_ctrl
  import btb_stats_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            lookupValid,
  input  logic            resValid,
  input  logic [ROWS-1:0] validVec,
  input  logic [ROWS-1:0] lookHitVec,
  input  logic [ROWS-1:0] resMatchVec,
  output btbStrobe_t      strobe
);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic [IDX_W-1:0] rrQ;
  logic [IDX_W-1:0] resIdx;
  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             freeAny;
  logic             resKnown;
  logic             replace;

  // priority encoders; the lowest index wins
  always_comb begin
    resIdx  = '0;
    lookIdx = '0;
    freeIdx = '0;
    freeAny = 1'b0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (resMatchVec[i]) resIdx  = IDX_W'(i);
      if (lookHitVec[i])  lookIdx = IDX_W'(i);
      if (!validVec[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign resKnown = |resMatchVec;
  assign replace  = resValid && !resKnown && !freeAny;

  always_comb begin
    strobe.wrEn    = resValid;
    strobe.wrAlloc = !resKnown;
    if (resKnown)     strobe.wrIdx = resIdx;
    else if (freeAny) strobe.wrIdx = freeIdx;
    else              strobe.wrIdx = rrQ;
    strobe.cntIdx = lookIdx;
    strobe.cntEn  = lookupValid && (|lookHitVec) &&
                    !(strobe.wrEn && (strobe.wrIdx == lookIdx));
  end

  always_ff @(posedge clk) begin
    if (rst)          rrQ <= '0;
    else if (replace) rrQ <= (rrQ == LAST_ROW) ? '0 : rrQ + IDX_ONE;
  end
endmodule

// File: rtl/btb_stats.sv
module btb_stats
  import btb_stats_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int SCORE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lookupValid,
  input  logic [ADDR_W-1:0]         lookupAddr,
  output logic                      rowMatch,
  output logic                      predHit,
  output logic [ADDR_W-1:0]         predTarget,
  output logic [CNT_W-1:0]          rowCount,
  output logic signed [SCORE_W-1:0] rowScore,
  input  logic                      resValid,
  input  logic [ADDR_W-1:0]         resAddr,
  input  logic [ADDR_W-1:0]         resTarget,
  input  logic                      resCorrect
);
  btbStrobe_t      strobe;
  logic [ROWS-1:0] validVec;
  logic [ROWS-1:0] lookHitVec;
  logic [ROWS-1:0] resMatchVec;

  btb_stats_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .lookupValid(lookupValid), .resValid(resValid),
    .validVec(validVec), .lookHitVec(lookHitVec), .resMatchVec(resMatchVec),
    .strobe(strobe)
  );

  btb_stats_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SCORE_W(SCORE_W)) dp_i (
    .clk(clk), .rst(rst),
    .lookupAddr(lookupAddr), .resAddr(resAddr), .resTarget(resTarget),
    .resCorrect(resCorrect), .strobe(strobe),
    .validVec(validVec), .lookHitVec(lookHitVec), .resMatchVec(resMatchVec),
    .rowMatch(rowMatch), .predHit(predHit), .predTarget(predTarget),
    .rowCount(rowCount), .rowScore(rowScore)
  );
endmodule

// File: rtl/btb_stats_chk.sv
module btb_stats_chk #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int SCORE_W = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      lookupValid,
  input logic [ADDR_W-1:0]         lookupAddr,
  input logic                      rowMatch,
  input logic                      predHit,
  input logic [ADDR_W-1:0]         predTarget,
  input logic [CNT_W-1:0]          rowCount,
  input logic signed [SCORE_W-1:0] rowScore,
  input logic                      resValid,
  input logic [ADDR_W-1:0]         resAddr,
  input logic [ADDR_W-1:0]         resTarget,
  input logic                      resCorrect
);
  localparam logic [CNT_W-1:0]          CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]          CNT_ONE   = CNT_W'(1);
  localparam logic signed [SCORE_W-1:0] SCORE_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
  localparam logic signed [SCORE_W-1:0] SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};
  localparam logic signed [SCORE_W-1:0] SCORE_ONE = SCORE_W'(1);

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rowMatch);

  assert_hit_needs_row_R2: assert property (@(posedge clk) disable iff (rst)
    predHit |-> rowMatch);

  assert_negative_blocks_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (rowMatch && rowScore < 0) |-> !predHit);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && lookupValid && predHit && !resValid && rowCount != CNT_MAX)
     && lookupAddr == $past(lookupAddr))
    |-> rowCount == $past(rowCount) + CNT_ONE);

  assert_target_written_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && resValid && rowMatch && resAddr == lookupAddr)
     && lookupAddr == $past(lookupAddr))
    |-> (rowMatch && predTarget == $past(resTarget)));

  assert_score_up_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && resValid && rowMatch && resAddr == lookupAddr && resCorrect
           && rowScore != SCORE_MAX) && lookupAddr == $past(lookupAddr))
    |-> rowScore == $past(rowScore) + SCORE_ONE);

  assert_score_down_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && resValid && rowMatch && resAddr == lookupAddr && !resCorrect
           && rowScore != SCORE_MIN) && lookupAddr == $past(lookupAddr))
    |-> rowScore == $past(rowScore) - SCORE_ONE);

  assert_fresh_row_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && resValid && !rowMatch && resAddr == lookupAddr)
     && lookupAddr == $past(lookupAddr))
    |-> (rowMatch && rowCount == '0 && rowScore == '0));

  assert_update_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && resValid && lookupValid && predHit && resAddr == lookupAddr)
     && lookupAddr == $past(lookupAddr))
    |-> rowCount == $past(rowCount));
endmodule

bind btb_stats btb_stats_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SCORE_W(SCORE_W)) chk_i (
  .clk(clk), .rst(rst), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
  .rowMatch(rowMatch), .predHit(predHit), .predTarget(predTarget),
  .rowCount(rowCount), .rowScore(rowScore), .resValid(resValid),
  .resAddr(resAddr), .resTarget(resTarget), .resCorrect(resCorrect)
);

// File: tb/btb_stats_tb.sv
module btb_stats_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        rowMatch, predHit;
  logic [31:0] predTarget;
  logic [7:0]  rowCount;
  logic signed [3:0] rowScore;
  logic        resValid = 1'b0;
  logic [31:0] resAddr = '0;
  logic [31:0] resTarget = '0;
  logic        resCorrect = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  btb_stats dut_i (
    .clk(clk), .rst(rst), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .rowMatch(rowMatch), .predHit(predHit), .predTarget(predTarget),
    .rowCount(rowCount), .rowScore(rowScore), .resValid(resValid),
    .resAddr(resAddr), .resTarget(resTarget), .resCorrect(resCorrect)
  );

  // behavioural reference model
  bit          mValid [8];
  logic [31:0] mAddr  [8];
  logic [31:0] mTgt   [8];
  int          mCnt   [8];
  int          mScore [8];
  int          mRr;

  function automatic int findRow(logic [31:0] a);
    for (int i = 0; i < 8; i++) if (mValid[i] && mAddr[i] == a) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
      mRr = 0;
    end else begin
      int h, w, m;
      h = findRow(lookupAddr);
      if (h >= 0 && (!lookupValid || mScore[h] < 0)) h = -1;
      w = -1;
      if (resValid) begin
        m = findRow(resAddr);
        if (m >= 0) begin
          w = m;
          mTgt[m] = resTarget;
          if (resCorrect) mScore[m] = (mScore[m] < 7) ? mScore[m] + 1 : 7;
          else            mScore[m] = (mScore[m] > -8) ? mScore[m] - 1 : -8;
        end else begin
          for (int i = 7; i >= 0; i--) if (!mValid[i]) w = i;
          if (w < 0) begin
            w = mRr;
            mRr = (mRr + 1) % 8;
          end
          mValid[w] = 1'b1; mAddr[w] = resAddr; mTgt[w] = resTarget;
          mCnt[w] = 0; mScore[w] = 0;
        end
      end
      if (h >= 0 && h != w && mCnt[h] < 255) mCnt[h]++;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int r;
    r = findRow(lookupAddr);
    check("R2", "rowMatch", rowMatch, r >= 0);
    if (r >= 0) begin
      check("R3", "predHit", predHit, mScore[r] >= 0);
      check("R5", "predTarget", predTarget, mTgt[r]);
      check("R4", "rowCount", rowCount, mCnt[r]);
      check("R6", "rowScore", rowScore, mScore[r]);
    end else begin
      check("R2", "predHit", predHit, 0);
      check("R2", "predTarget", predTarget, 0);
    end
  endtask

  task automatic step(bit lv, logic [31:0] la, bit rv, logic [31:0] ra,
                      logic [31:0] rt, bit rc);
    @(negedge clk);
    lookupValid = lv; lookupAddr = la;
    resValid = rv; resAddr = ra; resTarget = rt; resCorrect = rc;
    #1 compareAll();
  endtask

  function automatic logic [31:0] br(int k);
    return 32'h0000_4000 + 32'(k) * 32'd8;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: nothing matches after reset
    step(1, br(0), 0, 0, 0, 0);
    check("R1", "rowMatch after reset", rowMatch, 0);
    // R7: allocate, count 0 score 0, resCorrect ignored
    step(0, br(0), 1, br(0), 32'h100, 0);
    step(0, br(0), 0, 0, 0, 0);
    check("R7", "fresh score", rowScore, 0);
    check("R7", "fresh count", rowCount, 0);
    // R4: counted predictions
    repeat (3) step(1, br(0), 0, 0, 0, 0);
    step(0, br(0), 0, 0, 0, 0);
    check("R4", "count after three hits", rowCount, 3);
    // R5/R6: retarget with a correct outcome
    step(0, br(0), 1, br(0), 32'h200, 1);
    step(0, br(0), 0, 0, 0, 0);
    check("R5", "new target", predTarget, 32'h200);
    // R6 lower bound, R3 negative score blocks hit and counting
    repeat (12) step(0, br(0), 1, br(0), 32'h200, 0);
    step(1, br(0), 0, 0, 0, 0);
    check("R6", "score floor", rowScore, -8);
    check("R3", "no hit on negative", predHit, 0);
    step(1, br(0), 0, 0, 0, 0);
    check("R3", "count frozen", rowCount, 3);
    // R6 upper bound
    repeat (20) step(0, br(0), 1, br(0), 32'h200, 1);
    step(0, br(0), 0, 0, 0, 0);
    check("R6", "score ceiling", rowScore, 7);
    // R9: same-row collision keeps count
    step(1, br(0), 1, br(0), 32'h300, 1);
    step(0, br(0), 0, 0, 0, 0);
    check("R9", "count unchanged", rowCount, 3);
    check("R9", "target applied", predTarget, 32'h300);
    // R4 saturation
    repeat (260) step(1, br(0), 0, 0, 0, 0);
    step(0, br(0), 0, 0, 0, 0);
    check("R4", "count saturates", rowCount, 255);
    // fill rows 1..7
    for (int k = 1; k < 8; k++) step(0, br(k), 1, br(k), 32'h1000 + 32'(k), 1);
    // R10: hit on one row, resolve another
    step(1, br(2), 1, br(3), 32'h777, 1);
    step(0, br(2), 0, 0, 0, 0);
    check("R10", "other row counted", rowCount, 1);
    step(0, br(3), 0, 0, 0, 0);
    check("R10", "other row retargeted", predTarget, 32'h777);
    // R8: round-robin eviction, oldest first
    step(0, br(8), 1, br(8), 32'h888, 1);
    step(0, br(0), 0, 0, 0, 0);
    check("R8", "row of first branch evicted", rowMatch, 0);
    step(0, br(9), 1, br(9), 32'h999, 1);
    step(0, br(1), 0, 0, 0, 0);
    check("R8", "second branch evicted", rowMatch, 0);
    step(0, br(2), 0, 0, 0, 0);
    check("R8", "third branch kept", rowMatch, 1);
    // random mix over a small pool to force collisions
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 1) == 1, br($urandom_range(0, 11)),
           $urandom_range(0, 2) != 0, br($urandom_range(0, 11)),
           $urandom, $urandom_range(0, 3) != 0);
    // R1: reset again clears rows and pointer
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    step(0, br(5), 0, 0, 0, 0);
    check("R1", "empty after second reset", rowMatch, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule